// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block carries register writes from a fast core clock into a slow peripheral clock that is unrelated in phase. Each target register, plus one command register, is a lane. A core write stores the value in a core-side holding register and marks the lane busy. The lane then hands a toggle across to the slow side. The new value appears on the slow-side copy after the third rising slow-clock edge that follows the hand-off. A toggle comes back to the core through two flops and clears the busy flag. A lane does not take a second write while its busy flag is set. Such a write is dropped and reported on a one-cycle error flag.

A hold input lets software load several lanes without any of them moving on. When the hold is released, every loaded lane is launched in the same core cycle, and all of them land on the same slow edge. The build parameter `MODE` picks the immediate variant. In that variant, ordinary registers update in the core domain straight away and never show busy. A command is carried out on the first slow rising edge after it is written, and its busy flag reads 1 until that edge.

Top module: `lf_write_sync`

## Requirements
- R1: In delayed mode, an accepted write to register lane i is launched on the core edge after the write. `reg_q[i*DW +: DW]` keeps its old value through the first two slow rising edges after the launch and takes the new value at the third. Other lanes do not change.
- R2: In delayed mode, `busy[i]` reads 1 from the core edge that accepts a write to lane i.
- R3: `busy[i]` stays 1 through the landing edge. It clears on the second core edge after that slow edge.
- R4: While `freeze` is 1, written lanes are not launched. Their slow copies keep their old values and their busy flags stay 1 for as long as the hold lasts.
- R5: On the core edge after `freeze` falls, all loaded lanes launch together. All of them land on the same third slow edge.
- R6: A write to a lane whose busy flag is 1 is ignored. `wr_err` is 1 for exactly the core cycle after that write. Otherwise `wr_err` is 0.
- R7: A write with `wr_sel` greater than NREG selects no lane. It changes no output and raises no error.
- R8: In delayed mode, `wr_sel` = NREG selects the command lane. At the third slow edge after launch, `cmd_q` takes the value and `cmd_fire` is 1 for exactly one slow cycle.
- R9: In immediate mode, a register write shows on `reg_q` after the core edge that takes it. `busy` bits 0 to NREG-1 always read 0.
- R10: In immediate mode, after a command write `busy[NREG]` reads 1 until the first slow rising edge. At that edge `cmd_q` loads the value, `cmd_fire` is 1 for one slow cycle and the busy bit drops.
- R11: After reset, `reg_q`, `cmd_q`, `busy`, `wr_err` and `cmd_fire` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Core-domain synchronous reset, active high |
| slow_clk | input | 1 | Slow peripheral clock |
| slow_rst | input | 1 | Slow-domain synchronous reset, active high |
| wr_en | input | 1 | Core write strobe |
| wr_sel | input | SELW | Lane select: 0..NREG-1 registers, NREG command |
| wr_data | input | DW | Write value |
| freeze | input | 1 | Hold launches of loaded lanes while 1 |
| busy | output | NREG+1 | Per-lane busy flags, bit NREG for the command |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| reg_q | output | NREG*DW | Register copies, lane i at bits i*DW and up |
| cmd_q | output | DW | Last delivered command value |
| cmd_fire | output | 1 | One-slow-cycle command execute pulse |

## Verification
The launch flop moves one core edge after the write. The slow copy moves at the third slow rising edge after that core edge. The busy flag falls two core edges after the landing edge. In immediate mode the register copy moves at the write edge, and the command fires at the first slow edge after the write. The bench waits for the launch edge, counts slow edges, and samples 1 ns after each one. It checks the old value after the second edge and the new value after the third. Busy is sampled after each of the two core edges that follow. The slow clock is offset so its edges never fall on a core edge, and that keeps every sample point clear of any race.

// File: rtl/lfws_pkg.sv
package lfws_pkg;

    typedef enum logic {
        SYNC_DELAYED   = 1'b0,
        SYNC_IMMEDIATE = 1'b1
    } sync_mode_e;

    // core-side control state of one lane
    typedef struct packed {
        logic pend;   // written, waiting for launch
        logic req;    // launch toggle
        logic ack1;   // first return flop
        logic ack2;   // second return flop
    } core_lane_t;

    // slow-side synchronizer state of one lane
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } slow_lane_t;

    function automatic logic toggled(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/lfws_core_lane.sv
module lfws_core_lane
    import lfws_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] d,
    input  logic          freeze,
    input  logic          ack_async,
    output logic [DW-1:0] shadow,
    output logic          req,
    output logic          busy
);
    core_lane_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            shadow <= '0;
        end else begin
            st.ack1 <= ack_async;
            st.ack2 <= st.ack1;
            if (we) begin
                shadow  <= d;
                st.pend <= 1'b1;
            end else if (st.pend && !freeze) begin
                st.req  <= ~st.req;
                st.pend <= 1'b0;
            end
        end
    end

    assign req  = st.req;
    assign busy = st.pend | toggled(st.req, st.ack2);
endmodule

// File: rtl/lfws_slow_lane.sv
module lfws_slow_lane
    import lfws_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          slow_clk,
    input  logic          slow_rst,
    input  logic          req_async,
    input  logic [DW-1:0] shadow,
    output logic [DW-1:0] q,
    output logic          ack
);
    slow_lane_t st;
    logic       land;

    assign land = toggled(st.s2, st.s3);

    always_ff @(posedge slow_clk) begin
        if (slow_rst) begin
            st <= '0;
            q  <= '0;
        end else begin
            st.s1 <= req_async;
            st.s2 <= st.s1;
            st.s3 <= st.s2;
            if (land) q <= shadow;
        end
    end

    assign ack = st.s3;
endmodule

// File: rtl/lfws_imm_cmd.sv
module lfws_imm_cmd
    import lfws_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slow_clk,
    input  logic          slow_rst,
    input  logic          we,
    input  logic [DW-1:0] d,
    output logic          busy,
    output logic [DW-1:0] cmd_q,
    output logic          fire
);
    logic          tgl;
    logic [DW-1:0] val;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl <= 1'b0;
            val <= '0;
        end else if (we) begin
            tgl <= ~tgl;
            val <= d;
        end
    end

    always_ff @(posedge slow_clk) begin
        if (slow_rst) begin
            seen  <= 1'b0;
            fire  <= 1'b0;
            cmd_q <= '0;
        end else begin
            seen <= tgl;
            fire <= toggled(tgl, seen);
            if (toggled(tgl, seen)) cmd_q <= val;
        end
    end

    assign busy = toggled(tgl, seen);
endmodule

// File: rtl/lf_write_sync.sv
module lf_write_sync
    import lfws_pkg::*;
#(
    parameter int         NREG = 4,
    parameter int         DW   = 16,
    parameter sync_mode_e MODE = SYNC_DELAYED,
    localparam int        NLANE = NREG + 1,
    localparam int        SELW  = $clog2(NLANE + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slow_clk,
    input  logic               slow_rst,
    input  logic               wr_en,
    input  logic [SELW-1:0]    wr_sel,
    input  logic [DW-1:0]      wr_data,
    input  logic               freeze,
    output logic [NLANE-1:0]   busy,
    output logic               wr_err,
    output logic [NREG*DW-1:0] reg_q,
    output logic [DW-1:0]      cmd_q,
    output logic               cmd_fire
);
    logic [NLANE-1:0] hit;
    logic [NLANE-1:0] acc;
    logic [NLANE-1:0] busy_w;

    always_comb begin
        for (int i = 0; i < NLANE; i++) begin
            hit[i] = wr_en && (wr_sel == SELW'(i));
        end
        acc = hit & ~busy_w;
    end

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= |(hit & busy_w);
    end

    assign busy = busy_w;

    if (MODE == SYNC_DELAYED) begin : g_delayed
        logic [DW-1:0] shadow [NLANE];
        logic [DW-1:0] q      [NLANE];
        logic [NLANE-1:0] req;
        logic [NLANE-1:0] ack;

        for (genvar i = 0; i < NLANE; i++) begin : g_lane
            lfws_core_lane #(.DW(DW)) core_i (
                .clk      (clk),
                .rst      (rst),
                .we       (acc[i]),
                .d        (wr_data),
                .freeze   (freeze),
                .ack_async(ack[i]),
                .shadow   (shadow[i]),
                .req      (req[i]),
                .busy     (busy_w[i])
            );
            lfws_slow_lane #(.DW(DW)) slow_i (
                .slow_clk (slow_clk),
                .slow_rst (slow_rst),
                .req_async(req[i]),
                .shadow   (shadow[i]),
                .q        (q[i]),
                .ack      (ack[i])
            );
            if (i < NREG) begin : g_reg
                assign reg_q[i*DW +: DW] = q[i];
            end else begin : g_cmd
                logic ack_d;
                always_ff @(posedge slow_clk) begin
                    if (slow_rst) ack_d <= 1'b0;
                    else          ack_d <= ack[i];
                end
                assign cmd_q    = q[i];
                assign cmd_fire = toggled(ack[i], ack_d);
            end
        end
    end else begin : g_immediate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)         q <= '0;
                else if (acc[i]) q <= wr_data;
            end
            assign reg_q[i*DW +: DW] = q;
            assign busy_w[i] = 1'b0;
        end
        lfws_imm_cmd #(.DW(DW)) cmd_i (
            .clk     (clk),
            .rst     (rst),
            .slow_clk(slow_clk),
            .slow_rst(slow_rst),
            .we      (acc[NREG]),
            .d       (wr_data),
            .busy    (busy_w[NREG]),
            .cmd_q   (cmd_q),
            .fire    (cmd_fire)
        );
    end
endmodule

// File: rtl/lfws_chk.sv
module lfws_chk
    import lfws_pkg::*;
#(
    parameter int         NREG = 4,
    parameter int         DW   = 16,
    parameter sync_mode_e MODE = SYNC_DELAYED,
    localparam int        NLANE = NREG + 1,
    localparam int        SELW  = $clog2(NLANE + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               slow_clk,
    input logic               slow_rst,
    input logic               wr_en,
    input logic [SELW-1:0]    wr_sel,
    input logic [DW-1:0]      wr_data,
    input logic               freeze,
    input logic [NLANE-1:0]   busy,
    input logic               wr_err,
    input logic [NREG*DW-1:0] reg_q,
    input logic [DW-1:0]      cmd_q,
    input logic               cmd_fire
);
    // R6
    err_on_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_sel) < NLANE) && busy[wr_sel]) |=> wr_err);

    // R6
    no_spurious_err_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !wr_err);

    // R7
    invalid_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_sel) >= NLANE)) |=> !wr_err);

    if (MODE == SYNC_DELAYED) begin : g_del
        // R2
        busy_set_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (int'(wr_sel) < NLANE) && !busy[wr_sel]) |=> busy[$past(wr_sel)]);

        // R8
        fire_pulse_chk: assert property (@(posedge slow_clk) disable iff (slow_rst)
            cmd_fire |=> !cmd_fire);
    end else begin : g_imm
        // R9
        imm_reg_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (int'(wr_sel) < NREG))
            |=> reg_q[$past(wr_sel)*DW +: DW] == $past(wr_data));
    end
endmodule

bind lf_write_sync lfws_chk #(.NREG(NREG), .DW(DW), .MODE(MODE)) chk_i (.*);

// File: tb/lf_write_sync_tb_top.sv
`timescale 1ns/100ps
module lf_write_sync_tb_top;
    import lfws_pkg::*;

    localparam int NREG  = 2;
    localparam int DW    = 8;
    localparam int NLANE = NREG + 1;
    localparam int SELW  = $clog2(NLANE + 1);

    logic clk = 1'b0, sclk = 1'b0;
    logic rst = 1'b1, slow_rst = 1'b1;
    logic wr_en = 1'b0, freeze = 1'b0;
    logic [SELW-1:0] wr_sel = '0;
    logic [DW-1:0]   wr_data = '0;

    logic [NLANE-1:0]   d_busy, i_busy;
    logic               d_err, i_err, d_fire, i_fire;
    logic [NREG*DW-1:0] d_reg, i_reg;
    logic [DW-1:0]      d_cmd, i_cmd;

    int tests = 0, fails = 0;
    logic [DW-1:0] exp_reg [NREG];

    always #2.5 clk = ~clk;
    initial begin #1; forever #20 sclk = ~sclk; end

    lf_write_sync #(.NREG(NREG), .DW(DW), .MODE(SYNC_DELAYED)) dut_i (
        .clk(clk), .rst(rst), .slow_clk(sclk), .slow_rst(slow_rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .freeze(freeze),
        .busy(d_busy), .wr_err(d_err), .reg_q(d_reg), .cmd_q(d_cmd), .cmd_fire(d_fire));

    lf_write_sync #(.NREG(NREG), .DW(DW), .MODE(SYNC_IMMEDIATE)) dut_imm_i (
        .clk(clk), .rst(rst), .slow_clk(sclk), .slow_rst(slow_rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .freeze(freeze),
        .busy(i_busy), .wr_err(i_err), .reg_q(i_reg), .cmd_q(i_cmd), .cmd_fire(i_fire));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input int sel, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = SELW'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [DW-1:0] lane(input logic [NREG*DW-1:0] v, input int i);
        return v[i*DW +: DW];
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) exp_reg[i] = '0;
        #100;
        rst = 1'b0; slow_rst = 1'b0;
        @(negedge clk);
        // R11
        chk("R11 reg", d_reg, 0);  chk("R11 busy", d_busy, 0);
        chk("R11 err", d_err, 0);  chk("R11 fire", d_fire, 0);
        chk("R11 cmd", d_cmd, 0);  chk("R11 imm reg", i_reg, 0);

        // R1 R2 R3 sweep over lanes and values
        for (int ln = 0; ln < NREG; ln++) begin
            for (int k = 0; k < 4; k++) begin
                logic [DW-1:0] v;
                v = DW'((ln * 64 + k * 37 + 5) & 8'hFF);
                do_wr(ln, v);
                chk("R2 busy set", d_busy[ln], 1);
                chk("R6 no err", d_err, 0);
                @(posedge clk);
                repeat (2) @(posedge sclk);
                #1 chk("R1 old held", lane(d_reg, ln), exp_reg[ln]);
                @(posedge sclk);
                #1 chk("R1 landed", lane(d_reg, ln), v);
                exp_reg[ln] = v;
                chk("R1 other lane", lane(d_reg, 1 - ln), exp_reg[1 - ln]);
                chk("R3 busy at land", d_busy[ln], 1);
                @(posedge clk); #1 chk("R3 busy one edge", d_busy[ln], 1);
                @(posedge clk); #1 chk("R3 busy clear", d_busy[ln], 0);
            end
        end

        // R4 R5 freeze batching
        @(negedge clk) freeze = 1'b1;
        do_wr(0, 8'hA5);
        do_wr(1, 8'h3C);
        repeat (8) @(posedge sclk);
        #1 chk("R4 held 0", lane(d_reg, 0), exp_reg[0]);
        chk("R4 held 1", lane(d_reg, 1), exp_reg[1]);
        chk("R4 busy", d_busy, 3'b011);
        @(negedge clk) freeze = 1'b0;
        @(posedge clk);
        repeat (2) @(posedge sclk);
        #1 chk("R5 pre 0", lane(d_reg, 0), exp_reg[0]);
        chk("R5 pre 1", lane(d_reg, 1), exp_reg[1]);
        @(posedge sclk);
        #1 chk("R5 land 0", lane(d_reg, 0), 8'hA5);
        chk("R5 land 1", lane(d_reg, 1), 8'h3C);
        exp_reg[0] = 8'hA5; exp_reg[1] = 8'h3C;
        repeat (3) @(posedge clk);

        // R6 write while busy
        do_wr(0, 8'h5A);
        do_wr(0, 8'hFF);
        chk("R6 err pulse", d_err, 1);
        @(negedge clk) chk("R6 err one cycle", d_err, 0);
        repeat (6) @(posedge sclk);
        repeat (3) @(posedge clk);
        #1 chk("R6 first kept", lane(d_reg, 0), 8'h5A);
        chk("R6 busy clear", d_busy, 0);
        exp_reg[0] = 8'h5A;

        // R7 invalid select
        do_wr(NLANE, 8'h77);
        chk("R7 no err", d_err, 0);
        chk("R7 no busy", d_busy, 0);
        repeat (5) @(posedge sclk);
        #1 chk("R7 regs", d_reg, {exp_reg[1], exp_reg[0]});
        chk("R7 cmd", d_cmd, 0);

        // R8 delayed command
        do_wr(NREG, 8'hC3);
        chk("R8 busy bit", d_busy, 3'b100);
        @(posedge clk);
        repeat (2) @(posedge sclk);
        #1 chk("R8 no fire yet", d_fire, 0);
        @(posedge sclk);
        #1 chk("R8 fire", d_fire, 1);
        chk("R8 value", d_cmd, 8'hC3);
        @(posedge sclk);
        #1 chk("R8 single pulse", d_fire, 0);
        repeat (3) @(posedge clk);

        // R9 immediate registers
        for (int ln = 0; ln < NREG; ln++) begin
            for (int k = 0; k < 3; k++) begin
                logic [DW-1:0] v;
                v = DW'((ln * 91 + k * 29 + 1) & 8'hFF);
                do_wr(ln, v);
                chk("R9 imm value", lane(i_reg, ln), v);
                chk("R9 imm busy", i_busy[NREG-1:0], 0);
            end
        end

        // R10 immediate command
        @(posedge sclk);
        do_wr(NREG, 8'h4E);
        chk("R10 busy before edge", i_busy[NREG], 1);
        chk("R10 no fire", i_fire, 0);
        @(posedge sclk);
        #1 chk("R10 fire", i_fire, 1);
        chk("R10 value", i_cmd, 8'h4E);
        chk("R10 busy dropped", i_busy[NREG], 0);
        @(posedge sclk);
        #1 chk("R10 one cycle", i_fire, 0);

        // R6 immediate command rejected while busy
        @(posedge sclk);
        do_wr(NREG, 8'h12);
        do_wr(NREG, 8'h34);
        chk("R6 imm err", i_err, 1);
        @(posedge sclk);
        #1 chk("R6 imm first kept", i_cmd, 8'h12);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule